// File: doc/BRIEF.md
# Single-Cycle Bidirectional Shifter with Serial Fill

This block is a clocked word register with a shift network in front of it. On each rising clock edge it can do one of four things. It can take a new word from its parallel input. It can move its stored word toward the least significant end by any distance from zero to the word width minus one. It can move the stored word toward the most significant end by such a distance. Or it can keep what it holds. Every bit position left empty by a shift gets the value of a single serial fill input, so a caller can pad with ones, with zeros, or with a bit stream fed in several positions at a time.

The controls are resolved by a fixed priority. A synchronous active-low reset wins over everything. Load comes next, then the rightward shift, then the leftward shift. The shift network has two build-time variants. One is a logarithmic stage cascade and the other is a flat distance-decoded selector. Both give the same result.

Top module: `fill_shifter`

## Requirements
- R1: When rst_n is low at a rising clock edge, word_out becomes all zeros on that edge, whatever the other inputs are.
- R2: With rst_n high and ld_en high at a rising edge, word_out takes the value of word_in on that edge, whatever go_right, go_left, amt and fill_in are.
- R3: With rst_n high, ld_en low and go_right high, after the edge bit i of word_out equals the previous bit i+amt for i+amt below the width, and each of the top amt bits equals fill_in.
- R4: With rst_n high, ld_en low, go_right low and go_left high, after the edge bit i of word_out equals the previous bit i-amt for i at or above amt, and each of the low amt bits equals fill_in.
- R5: When go_right and go_left are both high and ld_en is low, the rightward shift of R3 is applied and the leftward one is not.
- R6: With rst_n high and ld_en, go_right and go_left all low, word_out keeps its value across the edge.
- R7: A shift with amt equal to 0 leaves word_out unchanged, in either direction and for either fill_in value.
- R8: Every shift distance from 0 to 7 (amt is 3 bits, width 8) completes in the single clock edge where it is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Parallel load request (highest priority after reset) |
| go_right | input | 1 | Shift toward the least significant bit |
| go_left | input | 1 | Shift toward the most significant bit |
| amt | input | 3 | Shift distance, 0 to 7 |
| fill_in | input | 1 | Value written into vacated bit positions |
| word_in | input | 8 | Word taken on a load |
| word_out | output | 8 | Registered word |

## Verification
The register is the only state in the block, and it drives the output pins directly. Any wrong internal value therefore shows up on word_out in the very cycle after the edge that produced it. A bad shift stage or a bad priority decode shows up as a mismatch against the bench's behavioural model on the first edge that uses that distance or that combination of controls. For this reason every distance is tried in both directions with both fill values, and with conflicting controls. An error in the hold or zero-distance paths would show as a value that changes when it should have stayed put.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
   typedef enum logic [1:0] {
      FSH_HOLD  = 2'd0,
      FSH_LOAD  = 2'd1,
      FSH_RIGHT = 2'd2,
      FSH_LEFT  = 2'd3
   } fsh_op_e;
endpackage

// File: rtl/fsh_op_sel.sv
module fsh_op_sel
   import fsh_pkg::*;
(
   input  logic    ld_en,
   input  logic    go_right,
   input  logic    go_left,
   output fsh_op_e op
);
   // fixed priority: load, then right, then left, else hold
   always_comb begin
      if (ld_en)         op = FSH_LOAD;
      else if (go_right) op = FSH_RIGHT;
      else if (go_left)  op = FSH_LEFT;
      else               op = FSH_HOLD;
   end
endmodule

// File: rtl/fsh_shift_net.sv
module fsh_shift_net #(
   parameter int WIDTH   = 8,
   parameter int AMT_W   = 3,
   parameter bit LOG_NET = 1'b1
) (
   input  logic [WIDTH-1:0] src,
   input  logic [AMT_W-1:0] amt,
   input  logic             fill,
   input  logic             to_right,
   output logic [WIDTH-1:0] dst
);
   generate
      if (LOG_NET) begin : g_log
         // stage s moves the word by 2**s positions when amt[s] is set
         logic [AMT_W:0][WIDTH-1:0] stg;
         assign stg[0] = src;
         for (genvar s = 0; s < AMT_W; s++) begin : g_stage
            localparam int K = 1 << s;
            for (genvar b = 0; b < WIDTH; b++) begin : g_bit
               logic r_bit;
               logic l_bit;
               if (b + K < WIDTH) begin : g_rsrc
                  assign r_bit = stg[s][b+K];
               end else begin : g_rfill
                  assign r_bit = fill;
               end
               if (b >= K) begin : g_lsrc
                  assign l_bit = stg[s][b-K];
               end else begin : g_lfill
                  assign l_bit = fill;
               end
               assign stg[s+1][b] = amt[s] ? (to_right ? r_bit : l_bit)
                                           : stg[s][b];
            end
         end
         assign dst = stg[AMT_W];
      end else begin : g_flat
         // one decoded candidate per distance
         always_comb begin
            dst = src;
            for (int j = 1; j < WIDTH; j++) begin
               if (amt == AMT_W'(j)) begin
                  if (to_right)
                     dst = (src >> j) | (fill ? ~({WIDTH{1'b1}} >> j) : '0);
                  else
                     dst = (src << j) | (fill ? ~({WIDTH{1'b1}} << j) : '0);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/fill_shifter.sv
module fill_shifter
   import fsh_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter bit LOG_NET = 1'b1,
   localparam int AMT_W  = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic             go_right,
   input  logic             go_left,
   input  logic [AMT_W-1:0] amt,
   input  logic             fill_in,
   input  logic [WIDTH-1:0] word_in,
   output logic [WIDTH-1:0] word_out
);
   generate
      if (WIDTH < 2 || (1 << AMT_W) != WIDTH) begin : g_bad_width
         $error("fill_shifter: WIDTH must be a power of two, at least 2");
      end
   endgenerate

   fsh_op_e          op;
   logic [WIDTH-1:0] shifted;

   fsh_op_sel u_sel (
      .ld_en    (ld_en),
      .go_right (go_right),
      .go_left  (go_left),
      .op       (op)
   );

   fsh_shift_net #(
      .WIDTH   (WIDTH),
      .AMT_W   (AMT_W),
      .LOG_NET (LOG_NET)
   ) u_net (
      .src      (word_out),
      .amt      (amt),
      .fill     (fill_in),
      .to_right (op == FSH_RIGHT),
      .dst      (shifted)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_out <= '0;
      end else begin
         case (op)
            FSH_LOAD:            word_out <= word_in;
            FSH_RIGHT, FSH_LEFT: word_out <= shifted;
            default:             word_out <= word_out;
         endcase
      end
   end
endmodule

// File: rtl/fill_shifter_chk.sv
module fill_shifter_chk #(
   parameter int WIDTH  = 8,
   localparam int AMT_W = $clog2(WIDTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ld_en,
   input logic             go_right,
   input logic             go_left,
   input logic [AMT_W-1:0] amt,
   input logic             fill_in,
   input logic [WIDTH-1:0] word_in,
   input logic [WIDTH-1:0] word_out
);
   logic seen;
   logic rst_q;
   always_ff @(posedge clk) begin
      seen  <= 1'b1;
      rst_q <= rst_n;
   end

   always @(posedge clk) begin
      if (seen && !rst_q)
         AST_RESET_ZERO: assert (word_out == '0); // R1
   end

   AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> word_out == $past(word_in)); // R2

   AST_RIGHT_FILL_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && go_right && amt != '0) |=> word_out[WIDTH-1] == $past(fill_in)); // R3

   AST_LEFT_FILL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && !go_right && go_left && amt != '0) |=> word_out[0] == $past(fill_in)); // R4

   AST_RIGHT_OVER_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && go_right && go_left) |=> word_out[0] == $past(word_out[amt])); // R5

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && !go_right && !go_left) |=> $stable(word_out)); // R6

   AST_ZERO_DIST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && (go_right || go_left) && amt == '0) |=> $stable(word_out)); // R7
endmodule

bind fill_shifter fill_shifter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ld_en    (ld_en),
   .go_right (go_right),
   .go_left  (go_left),
   .amt      (amt),
   .fill_in  (fill_in),
   .word_in  (word_in),
   .word_out (word_out)
);

// File: tb/fill_shifter_test.sv
`timescale 1ns/1ps
module fill_shifter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ld_en = 1'b0;
   logic       go_right = 1'b0;
   logic       go_left = 1'b0;
   logic [2:0] amt = '0;
   logic       fill_in = 1'b0;
   logic [7:0] word_in = '0;
   logic [7:0] word_out;

   int   tests = 0;
   int   fails = 0;
   bit   done = 1'b0;
   bit   model_ok = 1'b0;
   int   m;             // reference word as an integer
   string tag = "R1";

   always #5 clk = ~clk;

   fill_shifter uut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .go_right(go_right),
      .go_left(go_left), .amt(amt), .fill_in(fill_in),
      .word_in(word_in), .word_out(word_out)
   );

   // behavioural reference, evaluated at each rising edge
   always @(posedge clk) begin
      int n;
      int nxt;
      n = int'(amt);
      if (!rst_n) begin
         m = 0; tag = "R1";
      end else if (ld_en) begin
         m = int'(word_in); tag = "R2";
      end else if (go_right || go_left) begin
         nxt = 0;
         for (int i = 0; i < 8; i++) begin
            int srcpos;
            srcpos = go_right ? i + n : i - n;
            if (srcpos >= 0 && srcpos < 8) nxt = nxt | (((m >> srcpos) & 1) << i);
            else if (fill_in)              nxt = nxt | (1 << i);
         end
         m = nxt;
         if (n == 0)                tag = "R7";
         else if (go_right && go_left) tag = "R5";
         else if (go_right)         tag = "R3 R8";
         else                       tag = "R4 R8";
      end else begin
         tag = "R6";
      end
      model_ok = 1'b1;
   end

   // compare once per cycle, away from the rising edge
   always @(negedge clk) begin
      if (model_ok && !done) begin
         tests++;
         if (word_out !== 8'(m)) begin
            fails++;
            $display("FAIL %s: word_out=%h expected=%h", tag, word_out, 8'(m));
         end
      end
   end

   task automatic drive(input bit r, input bit l, input bit rr, input bit ll,
                        input int a, input bit f, input logic [7:0] w);
      @(negedge clk);
      #1;
      rst_n = r; ld_en = l; go_right = rr; go_left = ll;
      amt = 3'(a); fill_in = f; word_in = w;
   endtask

   initial begin
      // R1: reset with load requested still clears
      drive(0, 1, 0, 0, 0, 1, 8'hA5);
      drive(0, 1, 1, 1, 3, 1, 8'hFF);
      // R2: loads, including with both shift controls active
      drive(1, 1, 0, 0, 0, 0, 8'h3C);
      drive(1, 1, 1, 1, 5, 1, 8'hC3);
      // R6: idle holds
      drive(1, 0, 0, 0, 4, 1, 8'h00);
      drive(1, 0, 0, 0, 7, 0, 8'hFF);
      // R3/R8 right, every distance, both fills
      for (int f = 0; f < 2; f++)
         for (int a = 0; a < 8; a++) begin
            drive(1, 1, 0, 0, 0, 0, 8'b1001_0110);
            drive(1, 0, 1, 0, a, bit'(f), 8'h00);
         end
      // R4/R8 left, every distance, both fills
      for (int f = 0; f < 2; f++)
         for (int a = 0; a < 8; a++) begin
            drive(1, 1, 0, 0, 0, 0, 8'b0110_1001);
            drive(1, 0, 0, 1, a, bit'(f), 8'h00);
         end
      // R5: both directions, right wins
      drive(1, 1, 0, 0, 0, 0, 8'hF0);
      drive(1, 0, 1, 1, 2, 0, 8'h00);
      drive(1, 1, 0, 0, 0, 0, 8'h0F);
      drive(1, 0, 1, 1, 3, 1, 8'h00);
      // R7: zero distance, both fills, both directions
      drive(1, 1, 0, 0, 0, 0, 8'h5A);
      drive(1, 0, 1, 0, 0, 1, 8'h00);
      drive(1, 0, 0, 1, 0, 1, 8'hFF);
      drive(1, 0, 1, 1, 0, 0, 8'hFF);
      // serial fill chains
      drive(1, 0, 0, 1, 1, 1, 8'h00);
      drive(1, 0, 0, 1, 1, 0, 8'h00);
      drive(1, 0, 1, 0, 7, 1, 8'h00);
      // mid-run reset (R1)
      drive(0, 0, 1, 0, 1, 1, 8'h00);
      // mixed traffic
      for (int k = 0; k < 400; k++)
         drive(($urandom % 32) != 0, ($urandom % 4) == 0, $urandom % 2,
               $urandom % 2, int'($urandom % 8), $urandom % 2, 8'($urandom));
      drive(1, 0, 0, 0, 0, 0, 8'h00);
      @(negedge clk);
      #2;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #200us;
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule